// File: doc/BRIEF.md
# Conditional Branch Target Unit

This block resolves the relative jumps of a 16-bit microcontroller instruction set. Each cycle it may accept one instruction word together with the program counter, which has already been advanced past that word, and the four arithmetic flags (carry, zero, negative, overflow). It recognises whether the word belongs to the jump class and checks the word's condition code against the flags. It also forms the jump destination from a signed 10-bit word offset.

The result appears on registered outputs one clock after the input is accepted. It consists of a jump-class indication, a taken indication and the program counter to fetch from next. When the jump is not taken, or the word is not a jump at all, the next program counter is the incremented program counter that came in. Instruction fetch, flag generation and pipeline control sit outside this block.

Top module: `brt_top`

## Requirements
- R1: `outIsJump` is 1 exactly when bits 15:13 of the accepted instruction word are 3'b001, and 0 for any other value of those bits.
- R2: For a jump word, the condition code is bits 12:10. Code 0 is taken when Z=0, code 1 when Z=1, code 2 when C=0, code 3 when C=1, code 4 when N=1, and code 7 is always taken.
- R3: Code 5 is taken when N equals V. Code 6 is taken when N differs from V.
- R4: For a taken jump, `nextPc` = `pcInc` + 2 × (bits 9:0 read as a two's-complement number), with bit 9 as the sign and the sum kept modulo 2^16.
- R5: When the word is not a jump, or the jump is not taken, `outTaken` is 0 and `nextPc` equals the accepted `pcInc`.
- R6: `outValid` is 1 in the cycle after `inValid` was 1 at a clock edge, and 0 in the cycle after `inValid` was 0.
- R7: While no input is accepted, `outIsJump`, `outTaken` and `nextPc` keep their last values, whatever the other inputs do.
- R8: An active-low `rstN` clears `outValid`, `outIsJump`, `outTaken` and `nextPc` to 0.
- R9: A flag that a condition code does not name has no effect on that code's outcome. For example, code 0 with Z=0 is taken whatever C, N and V are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| inValid | input | 1 | Accept the inputs at this edge |
| instrWord | input | 16 | Instruction word under evaluation |
| pcInc | input | 16 | Address of the word plus 2 |
| flagC | input | 1 | Carry flag |
| flagZ | input | 1 | Zero flag |
| flagN | input | 1 | Negative flag |
| flagV | input | 1 | Overflow flag |
| outValid | output | 1 | Result registers hold a fresh result |
| outIsJump | output | 1 | Accepted word is in the jump class |
| outTaken | output | 1 | Jump is taken |
| nextPc | output | 16 | Program counter to fetch next |

## Verification
Every condition code is applied twice: once with the flags set so that the jump is taken, and once set so that it is not. This shows that each code reads the right flag with the right polarity. The greater-or-equal and less-than codes are applied with all four N/V combinations, which separates an equality test from a test of either flag alone.

Offsets at the positive limit, at the negative limit, at -1 and one that wraps past address zero show whether sign extension and the doubling are correct. Words outside the jump class, and codes whose named flag matches while other flags are noisy, show that the class check gates the result and that unnamed flags have no effect.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [2:0] {
    CondNotZero = 3'd0,
    CondZero    = 3'd1,
    CondNoCarry = 3'd2,
    CondCarry   = 3'd3,
    CondNeg     = 3'd4,
    CondGe      = 3'd5,
    CondLt      = 3'd6,
    CondAlways  = 3'd7
  } condCode_t;

  typedef struct packed {
    logic load;
    logic isJump;
    logic taken;
  } brtStrobe_t;

  localparam logic [2:0] JUMP_CLASS = 3'b001;
endpackage

// File: rtl/brt_ctrl.sv
module brt_ctrl
  import brt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] instrWord,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic              flagN,
  input  logic              flagV,
  output brtStrobe_t        strobe,
  output logic              outValid,
  output logic              outIsJump,
  output logic              outTaken
);
  localparam int CLASS_LSB = DATA_W - 3;
  localparam int COND_LSB  = OFF_W;
  localparam int COND_MSB  = OFF_W + 2;

  condCode_t condCode;
  logic      isJump;
  logic      condMet;

  assign isJump   = (instrWord[DATA_W-1:CLASS_LSB] == JUMP_CLASS);
  assign condCode = condCode_t'(instrWord[COND_MSB:COND_LSB]);

  always_comb begin
    unique case (condCode)
      CondNotZero: condMet = !flagZ;
      CondZero:    condMet = flagZ;
      CondNoCarry: condMet = !flagC;
      CondCarry:   condMet = flagC;
      CondNeg:     condMet = flagN;
      CondGe:      condMet = (flagN == flagV);
      CondLt:      condMet = (flagN != flagV);
      default:     condMet = 1'b1;
    endcase
  end

  assign strobe.load   = inValid;
  assign strobe.isJump = isJump;
  assign strobe.taken  = isJump && condMet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outIsJump <= 1'b0;
      outTaken  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outIsJump <= strobe.isJump;
        outTaken  <= strobe.taken;
      end
    end
  end

  // R6: valid output follows accepted input by one cycle
  p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R1: a word outside the jump class never reports a jump
  p_class_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrWord[DATA_W-1:CLASS_LSB] != JUMP_CLASS) |=> (!outIsJump && !outTaken));
  // R2: the unconditional code on a jump word is always taken
  p_always_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrWord[DATA_W-1:CLASS_LSB] == JUMP_CLASS
     && instrWord[COND_MSB:COND_LSB] == 3'd7) |=> outTaken);
  // R7: flags hold while idle
  p_hold_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outIsJump) && $stable(outTaken)));
endmodule

// File: rtl/brt_datapath.sv
module brt_datapath
  import brt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  brtStrobe_t        strobe,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] pcInc,
  output logic [DATA_W-1:0] nextPc
);
  localparam int EXT_W = DATA_W - OFF_W;

  logic [DATA_W-1:0] offsetExt;
  logic [DATA_W-1:0] byteOffset;
  logic [DATA_W-1:0] target;
  logic [DATA_W-1:0] nextPcD;

  assign offsetExt  = {{EXT_W{instrWord[OFF_W-1]}}, instrWord[OFF_W-1:0]};
  assign byteOffset = offsetExt << 1;
  assign target     = pcInc + byteOffset;
  assign nextPcD    = strobe.taken ? target : pcInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nextPc <= '0;
    else if (strobe.load) nextPc <= nextPcD;
  end

  // R5: a not-taken result falls through to the incremented PC
  p_fallthru_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.taken) |=> (nextPc == $past(pcInc)));
  // R7: the PC register holds while idle
  p_hold_pc_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(nextPc));
  // R4: a taken jump always lands on an even distance from pcInc
  p_even_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.taken) |=> ((nextPc[0] ^ $past(pcInc[0])) == 1'b0));
endmodule

// File: rtl/brt_top.sv
module brt_top
  import brt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] pcInc,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic              flagN,
  input  logic              flagV,
  output logic              outValid,
  output logic              outIsJump,
  output logic              outTaken,
  output logic [DATA_W-1:0] nextPc
);
  brtStrobe_t strobe;

  brt_ctrl #(.DATA_W(DATA_W), .OFF_W(OFF_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV),
    .strobe(strobe), .outValid(outValid), .outIsJump(outIsJump),
    .outTaken(outTaken)
  );

  brt_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instrWord(instrWord),
    .pcInc(pcInc), .nextPc(nextPc)
  );

  // R5: taken is only ever reported together with the jump class
  p_taken_jump_r5: assert property (@(posedge clk) disable iff (!rstN)
    outTaken |-> outIsJump);
endmodule

// File: tb/brt_top_tb_top.sv
`timescale 1ns/1ps
module brt_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [15:0] pcInc = '0;
  logic        flagC = 1'b0, flagZ = 1'b0, flagN = 1'b0, flagV = 1'b0;
  logic        outValid, outIsJump, outTaken;
  logic [15:0] nextPc;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  brt_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .pcInc(pcInc), .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV),
    .outValid(outValid), .outIsJump(outIsJump), .outTaken(outTaken),
    .nextPc(nextPc)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] mkJump(input int code, input int off);
    logic [9:0] o;
    o = 10'(off);
    return {3'b001, 3'(code), o};
  endfunction

  // Apply one word, sample results at the following negedge
  task automatic apply(input logic [15:0] w, input logic [15:0] pc,
                       input logic [3:0] cznv);
    @(negedge clk);
    instrWord = w; pcInc = pc;
    {flagC, flagZ, flagN, flagV} = cznv;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectJump(input string req, input int code, input int off,
                            input logic [3:0] cznv, input bit expTaken);
    logic [15:0] pc, exPc;
    pc = 16'h1000;
    exPc = expTaken ? 16'(pc + 16'(off * 2)) : pc;
    apply(mkJump(code, off), pc, cznv);
    check({req, " valid"}, {15'd0, outValid}, 16'd1);
    check({req, " isJump"}, {15'd0, outIsJump}, 16'd1);
    check({req, " taken"}, {15'd0, outTaken}, {15'd0, expTaken});
    check({req, " nextPc"}, nextPc, exPc);
  endtask

  task automatic testReset();
    check("R8 valid", {15'd0, outValid}, 16'd0);
    check("R8 isJump", {15'd0, outIsJump}, 16'd0);
    check("R8 taken", {15'd0, outTaken}, 16'd0);
    check("R8 nextPc", nextPc, 16'd0);
  endtask

  // flags order: {C,Z,N,V}
  task automatic testSimpleCodes();
    expectJump("R2 code0 Z=0", 0, 8, 4'b0000, 1);
    expectJump("R2 code0 Z=1", 0, 8, 4'b0100, 0);
    expectJump("R2 code1 Z=1", 1, 8, 4'b0100, 1);
    expectJump("R2 code1 Z=0", 1, 8, 4'b0000, 0);
    expectJump("R2 code2 C=0", 2, 8, 4'b0000, 1);
    expectJump("R2 code2 C=1", 2, 8, 4'b1000, 0);
    expectJump("R2 code3 C=1", 3, 8, 4'b1000, 1);
    expectJump("R2 code3 C=0", 3, 8, 4'b0000, 0);
    expectJump("R2 code4 N=1", 4, 8, 4'b0010, 1);
    expectJump("R2 code4 N=0", 4, 8, 4'b0000, 0);
    expectJump("R2 code7 none", 7, 8, 4'b0000, 1);
    expectJump("R2 code7 all", 7, 8, 4'b1111, 1);
  endtask

  task automatic testSignedCodes();
    for (int nv = 0; nv < 4; nv++) begin
      bit n = nv[1];
      bit v = nv[0];
      expectJump("R3 code5", 5, 4, {2'b00, n, v}, n == v);
      expectJump("R3 code6", 6, 4, {2'b00, n, v}, n != v);
    end
  endtask

  task automatic testOffsets();
    expectJump("R4 max pos", 7, 511, 4'b0000, 1);
    expectJump("R4 max neg", 7, -512, 4'b0000, 1);
    expectJump("R4 minus one", 7, -1, 4'b0000, 1);
    apply(mkJump(7, -3), 16'h0002, 4'b0000);
    check("R4 wrap nextPc", nextPc, 16'hFFFC);
  endtask

  task automatic testNonJump();
    apply(16'h4130, 16'h2222, 4'b0100);
    check("R1 class mov isJump", {15'd0, outIsJump}, 16'd0);
    check("R5 class mov taken", {15'd0, outTaken}, 16'd0);
    check("R5 class mov nextPc", nextPc, 16'h2222);
    apply(16'h3C10, 16'h3000, 4'b0000);
    check("R1 class 001 isJump", {15'd0, outIsJump}, 16'd1);
    apply({3'b011, 3'd7, 10'd16}, 16'h3000, 4'b0000);
    check("R1 class 011 isJump", {15'd0, outIsJump}, 16'd0);
    check("R5 class 011 nextPc", nextPc, 16'h3000);
    apply({3'b000, 3'd7, 10'd16}, 16'h3000, 4'b0000);
    check("R1 class 000 isJump", {15'd0, outIsJump}, 16'd0);
  endtask

  task automatic testIgnoredFlags();
    expectJump("R9 code0 noisy", 0, 2, 4'b1011, 1);
    expectJump("R9 code3 noisy", 3, 2, 4'b0111, 0);
    expectJump("R9 code4 noisy", 4, 2, 4'b1101, 0);
  endtask

  task automatic testHoldAndValid();
    apply(mkJump(7, 20), 16'h0400, 4'b0000);
    check("R6 valid after accept", {15'd0, outValid}, 16'd1);
    instrWord = 16'h4130; pcInc = 16'h7777; flagZ = 1'b1;
    @(negedge clk);
    check("R6 valid drops", {15'd0, outValid}, 16'd0);
    @(negedge clk);
    check("R7 hold nextPc", nextPc, 16'h0428);
    check("R7 hold isJump", {15'd0, outIsJump}, 16'd1);
    check("R7 hold taken", {15'd0, outTaken}, 16'd1);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R8 mid valid", {15'd0, outValid}, 16'd0);
    check("R8 mid nextPc", nextPc, 16'd0);
    rstN = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog got timeout expected completion");
      finish();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testSimpleCodes();
    testSignedCodes();
    testOffsets();
    testNonJump();
    testIgnoredFlags();
    testHoldAndValid();
    testMidReset();
    finish();
  end
endmodule